// File: doc/BRIEF.md
# Read-Only Port to ISA Bridge

Some host ports can only issue read cycles: they have an address bus, a read strobe and a data bus into the host, but no write strobe and no path for data out of the host. This bridge lets such a host both read and write a small ISA-like peripheral of 8 or 16 bits. The host selects one of two address windows for each access. An access in the read window becomes a peripheral read, and the data returns on the host data bus. An access in the write window becomes a peripheral write. Because the host cannot send data, the write data byte travels on the host address lines.

The peripheral register index comes from host address bits 13..9. The peripheral always sits at base 0x300. The host strobe is synchronised to the block clock, and each rising edge starts exactly one peripheral cycle. The peripheral strobe lasts a parameterised number of clocks.

In 16-bit mode the host can only place one byte on the address lines at a time, so a word write takes two accesses. First a read-window access returns the peripheral word and also captures the low byte. Then a write-window access supplies the high byte and fires one 16-bit write.

Top module: `rdport_isa_bridge`

## Requirements
- R1: The peripheral address is 0x300 OR'ed with host address bits 13..9, latched at the start of each peripheral cycle.
- R2: A window A access starts one peripheral read. A window B access starts one peripheral write. If both selects are high, the access is a write. If neither is high, no strobe is issued.
- R3: In byte mode (mode_wide=0), a read places peripheral data bits 7..0 on host data bits 15..8, and host data bits 7..0 are zero.
- R4: In byte mode, a write drives peripheral data {8'h00, host address bits 8..1}.
- R5: In 16-bit mode (mode_wide=1), a read returns all 16 peripheral data bits unchanged on the host data bus.
- R6: In 16-bit mode, a window A access stores host address bits 8..1 as the held low byte. Byte-mode accesses leave the held byte unchanged.
- R7: In 16-bit mode, a window B access writes {host address bits 8..1, held low byte} to the peripheral.
- R8: Each rising edge of the host strobe gives exactly one peripheral strobe, and that strobe is high for exactly PULSE_CLKS clocks.
- R9: Read data is registered when the read strobe ends. It stays on the host data bus while the host strobe remains high, and it returns to zero after the strobe is released.
- R10: During a window B access, the host data output is zero.
- R11: Synchronous reset deasserts both peripheral strobes, zeroes the host data output and clears the held low byte.
- R12: The peripheral write data does not change while the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | Static mode: 0 = byte transfers, 1 = 16-bit transfers |
| host_addr | input | HOST_AW | Host address bus; bits 13..9 give the register index, bits 8..1 give the data byte |
| host_rd | input | 1 | Host read strobe, asynchronous to clk |
| win_a_sel | input | 1 | Host access falls in the read window |
| win_b_sel | input | 1 | Host access falls in the write window |
| host_data | output | DW | Data returned to the host |
| per_addr | output | PER_AW | Peripheral address |
| per_wdata | output | DW | Peripheral write data |
| per_rdata | input | DW | Peripheral read data |
| per_rd | output | 1 | Peripheral read strobe, active high |
| per_wr | output | 1 | Peripheral write strobe, active high |

## Verification
The stimulus table covers both modes and both windows. It uses register indices at the lowest, highest and middle values, data bytes of all zeros, all ones and mixed patterns, and peripheral read words whose two bytes differ. This makes a lane swap or a dropped byte visible as a wrong value.

The 16-bit write pairs are arranged to separate the roles of the held byte. One write follows a byte-mode read, which must leave the held byte alone. One write follows a read that captured zero. One write reuses a byte captured two accesses earlier.

Directed cases cover the remaining behaviour:
- a select-less access, which must produce no strobe;
- a both-select access, which must produce a write;
- a long host strobe, which must keep the read data held;
- a reset between the two halves of a word write, which must clear the held byte.

// File: rtl/isa_brg_pkg.sv
package isa_brg_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PULSE = 2'd1,
    SQ_HOLD  = 2'd2
  } seq_state_t;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_kind_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_in};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/cycle_seq.sv
module cycle_seq
  import isa_brg_pkg::*;
#(
  parameter int PULSE_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic level,
  input  logic sel_a,
  input  logic sel_b,
  output logic start,
  output logic start_wr,
  output logic finish_rd,
  output logic release_o,
  output logic per_rd,
  output logic per_wr
);
  localparam int CW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PULSE_CLKS - 1);

  seq_state_t    state_q;
  op_kind_t      op_q;
  logic [CW-1:0] cnt_q;
  logic          finish;

  assign start     = (state_q == SQ_IDLE) && rise && (sel_a || sel_b);
  assign start_wr  = sel_b;
  assign finish    = (state_q == SQ_PULSE) && (cnt_q == LAST);
  assign finish_rd = finish && (op_q == OP_READ);
  assign release_o = (state_q == SQ_HOLD) && !level;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      op_q    <= OP_READ;
      cnt_q   <= '0;
      per_rd  <= 1'b0;
      per_wr  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            state_q <= SQ_PULSE;
            cnt_q   <= '0;
            op_q    <= start_wr ? OP_WRITE : OP_READ;
            per_rd  <= !start_wr;
            per_wr  <= start_wr;
          end
        end
        SQ_PULSE: begin
          if (finish) begin
            state_q <= SQ_HOLD;
            per_rd  <= 1'b0;
            per_wr  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (!level) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bridge_datapath.sv
module bridge_datapath #(
  parameter int HOST_AW  = 14,
  parameter int PER_AW   = 10,
  parameter int DW       = 16,
  parameter int PER_BASE = 'h300,
  parameter int REG_LSB  = 9,
  parameter int REG_BITS = 5,
  parameter int DATA_LSB = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_wide,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               start,
  input  logic               start_wr,
  input  logic               finish_rd,
  input  logic               release_i,
  input  logic [DW-1:0]      per_rdata,
  output logic [PER_AW-1:0]  per_addr,
  output logic [DW-1:0]      per_wdata,
  output logic [DW-1:0]      host_data
);
  localparam int BW = DW / 2;
  localparam logic [PER_AW-1:0] BASE_V = PER_AW'(PER_BASE);

  logic [BW-1:0]       hold_q;
  logic [BW-1:0]       addr_byte;
  logic [REG_BITS-1:0] reg_idx;
  logic                unused_addr_lsb;

  assign addr_byte       = host_addr[DATA_LSB +: BW];
  assign reg_idx         = host_addr[REG_LSB +: REG_BITS];
  assign unused_addr_lsb = host_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      per_addr  <= BASE_V;
      per_wdata <= '0;
      host_data <= '0;
    end else begin
      if (start) begin
        per_addr <= BASE_V | PER_AW'(reg_idx);
        if (start_wr) begin
          per_wdata <= mode_wide ? {addr_byte, hold_q} : {{BW{1'b0}}, addr_byte};
          host_data <= '0;
        end else if (mode_wide) begin
          hold_q <= addr_byte;
        end
      end
      if (finish_rd) begin
        host_data <= mode_wide ? per_rdata : {per_rdata[BW-1:0], {BW{1'b0}}};
      end else if (release_i) begin
        host_data <= '0;
      end
    end
  end
endmodule

// File: rtl/rdport_isa_bridge.sv
module rdport_isa_bridge #(
  parameter int HOST_AW    = 14,
  parameter int PER_AW     = 10,
  parameter int DW         = 16,
  parameter int PER_BASE   = 'h300,
  parameter int PULSE_CLKS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_wide,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_rd,
  input  logic               win_a_sel,
  input  logic               win_b_sel,
  output logic [DW-1:0]      host_data,
  output logic [PER_AW-1:0]  per_addr,
  output logic [DW-1:0]      per_wdata,
  input  logic [DW-1:0]      per_rdata,
  output logic               per_rd,
  output logic               per_wr
);
  logic s_level, s_rise;
  logic start, start_wr, finish_rd, release_c;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(host_rd), .level(s_level), .rise(s_rise)
  );

  cycle_seq #(.PULSE_CLKS(PULSE_CLKS)) u_seq (
    .clk(clk), .rst(rst), .rise(s_rise), .level(s_level),
    .sel_a(win_a_sel), .sel_b(win_b_sel),
    .start(start), .start_wr(start_wr), .finish_rd(finish_rd),
    .release_o(release_c), .per_rd(per_rd), .per_wr(per_wr)
  );

  bridge_datapath #(
    .HOST_AW(HOST_AW), .PER_AW(PER_AW), .DW(DW), .PER_BASE(PER_BASE)
  ) u_dp (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .host_addr(host_addr),
    .start(start), .start_wr(start_wr), .finish_rd(finish_rd),
    .release_i(release_c), .per_rdata(per_rdata),
    .per_addr(per_addr), .per_wdata(per_wdata), .host_data(host_data)
  );
endmodule

// File: rtl/rdport_isa_bridge_chk.sv
module rdport_isa_bridge_chk #(
  parameter int DW         = 16,
  parameter int PULSE_CLKS = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_wide,
  input logic [DW-1:0] host_data,
  input logic [DW-1:0] per_wdata,
  input logic          per_rd,
  input logic          per_wr
);
  logic [31:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)                 run_q <= '0;
    else if (per_rd || per_wr) run_q <= run_q + 1;
    else                     run_q <= '0;
  end

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(per_rd && per_wr));

  // R8
  strobe_max_chk: assert property (@(posedge clk) disable iff (rst)
    (per_rd || per_wr) |-> (run_q < PULSE_CLKS));

  // R8
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(per_rd || per_wr) |-> (run_q == PULSE_CLKS));

  // R10
  wr_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    per_wr |-> (host_data == '0));

  // R12
  wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (per_wr && $past(per_wr)) |-> $stable(per_wdata));

  // R3
  byte_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_wide |-> (host_data[DW/2-1:0] == '0));
endmodule

bind rdport_isa_bridge rdport_isa_bridge_chk #(.DW(DW), .PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk(clk), .rst(rst), .mode_wide(mode_wide), .host_data(host_data),
  .per_wdata(per_wdata), .per_rd(per_rd), .per_wr(per_wr)
);

// File: tb/rdport_isa_bridge_bench.sv
module rdport_isa_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 4;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wide = 1'b0;
  logic [13:0] host_addr = '0;
  logic        host_rd = 1'b0;
  logic        win_a_sel = 1'b0;
  logic        win_b_sel = 1'b0;
  logic [15:0] host_data;
  logic [9:0]  per_addr;
  logic [15:0] per_wdata;
  logic [15:0] per_rdata = '0;
  logic        per_rd, per_wr;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdport_isa_bridge #(.PULSE_CLKS(PULSE)) u_rdport_isa_bridge (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .host_addr(host_addr),
    .host_rd(host_rd), .win_a_sel(win_a_sel), .win_b_sel(win_b_sel),
    .host_data(host_data), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_rd(per_rd), .per_wr(per_wr)
  );

  // mode | win(01=A,10=B) | addr | rdata | exp addr | exp wdata | exp host | kind(1 rd,2 wr)
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 14'h0600, 16'hA55A, 10'h303, 16'h0000, 16'h5A00, 2'd1},
    {1'b0, 2'b10, 14'h3F86, 16'h0000, 10'h31F, 16'h00C3, 16'h0000, 2'd2},
    {1'b1, 2'b01, 14'h20FC, 16'h1234, 10'h310, 16'h0000, 16'h1234, 2'd1},
    {1'b1, 2'b10, 14'h2136, 16'h0000, 10'h310, 16'h9B7E, 16'h0000, 2'd2},
    {1'b0, 2'b01, 14'h0000, 16'hFF01, 10'h300, 16'h0000, 16'h0100, 2'd1},
    {1'b1, 2'b10, 14'h1422, 16'h0000, 10'h30A, 16'h117E, 16'h0000, 2'd2},
    {1'b1, 2'b01, 14'h2A00, 16'hBEEF, 10'h315, 16'h0000, 16'hBEEF, 2'd1},
    {1'b1, 2'b10, 14'h2BFE, 16'h0000, 10'h315, 16'hFF00, 16'h0000, 2'd2}
  };

  // bus monitor, cleared from posedge-driven flag, sampled at negedge
  bit          clr = 1'b0;
  int          rd_cyc, wr_cyc;
  logic [9:0]  mon_addr;
  logic [15:0] mon_wd;
  logic [15:0] mon_hd_wr;

  always @(negedge clk) begin
    if (clr) begin
      rd_cyc = 0; wr_cyc = 0; mon_addr = '0; mon_wd = '0; mon_hd_wr = '0;
    end else begin
      if (per_rd) begin rd_cyc++; mon_addr = per_addr; end
      if (per_wr) begin
        wr_cyc++; mon_addr = per_addr; mon_wd = per_wdata;
        mon_hd_wr = mon_hd_wr | host_data;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] held_hd;

  task automatic access(input logic mw, input logic [1:0] win, input logic [13:0] a,
                        input logic [15:0] rd, input int hold_cycles);
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
    @(negedge clk);
    mode_wide = mw; win_a_sel = win[0]; win_b_sel = win[1];
    host_addr = a; per_rdata = rd;
    @(negedge clk); host_rd = 1'b1;
    repeat (PULSE + 8 + hold_cycles) @(negedge clk);
    held_hd = host_data;
    host_rd = 1'b0;
    repeat (6) @(negedge clk);
    win_a_sel = 1'b0; win_b_sel = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 host_data after reset", 32'(host_data), 32'h0);
    check("R11 strobes after reset", {30'd0, per_rd, per_wr}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [76:0] v;
      v = VEC[i];
      access(v[76], v[75:74], v[73:60], v[59:44], 0);
      // R1
      check($sformatf("R1 per_addr vec%0d", i), 32'(mon_addr), 32'(v[43:34]));
      if (v[1:0] == 2'd1) begin
        // R2 R8
        check($sformatf("R2 R8 read strobe cycles vec%0d", i), rd_cyc, PULSE);
        check($sformatf("R2 no write vec%0d", i), wr_cyc, 0);
        // R3 R5 R9
        check($sformatf("R3 R5 R9 held host data vec%0d", i), 32'(held_hd), 32'(v[17:2]));
      end else begin
        check($sformatf("R2 R8 write strobe cycles vec%0d", i), wr_cyc, PULSE);
        check($sformatf("R2 no read vec%0d", i), rd_cyc, 0);
        // R4 R6 R7
        check($sformatf("R4 R6 R7 write data vec%0d", i), 32'(mon_wd), 32'(v[33:18]));
        // R10
        check($sformatf("R10 host data during write vec%0d", i), 32'(mon_hd_wr | held_hd), 32'h0);
      end
      // R9 release
      check($sformatf("R9 host data after release vec%0d", i), 32'(host_data), 32'h0);
    end

    // R2 neither window selected
    access(1'b0, 2'b00, 14'h0600, 16'h1111, 0);
    check("R2 no select no read", rd_cyc, 0);
    check("R2 no select no write", wr_cyc, 0);
    check("R2 no select host data", 32'(held_hd), 32'h0);

    // R2 both selects -> write
    access(1'b0, 2'b11, 14'h0654, 16'h2222, 0);
    check("R2 both selects write", wr_cyc, PULSE);
    check("R2 both selects no read", rd_cyc, 0);
    check("R4 both selects wdata", 32'(mon_wd), 32'h002A);

    // R9 long hold
    access(1'b1, 2'b01, 14'h0200, 16'hC0DE, 60);
    check("R9 data held over long strobe", 32'(held_hd), 32'hC0DE);
    check("R8 one strobe for long host strobe", rd_cyc, PULSE);

    // R11 reset clears held byte; R6 capture
    access(1'b1, 2'b01, 14'h0084, 16'h0000, 0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    access(1'b1, 2'b10, 14'h0002, 16'h0000, 0);
    check("R11 R7 hold cleared by reset", 32'(mon_wd), 32'h0100);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule